// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources. It gives each source a priority level that software can program, and it tells the processor core which level, if any, is the most urgent. For every source it keeps a pending bit, a mask bit and a force bit. A source can be captured on a rising edge of its request line, or it can follow the level of that line.

The block drives a 3-bit request level toward the core. It also drives a flag that says whether that level gets past the core's current 3-bit mask. When the core runs an acknowledge cycle, the block answers one cycle later with an 8-bit vector number. For source n the vector is 64 + n. When nothing is requesting, it returns the spurious vector 24. In the same cycle it clears the winner's pending bit if that bit was edge-captured.

Software reaches the configuration and status through a simple word-addressed register port. Writes are synchronous and reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each source n has a 3-bit priority level in register 4, bits [4n+2:4n] (for n < 8). A source whose level is 0 never requests.
- R2: Register 0 reads the pending bit of each source at bit n. A source in edge mode becomes pending on a rising edge of its line. A source in level mode reads as pending while its line is high.
- R3: Register 1 holds one mask bit per source, where 1 blocks the source from the request level. A masked source still shows as pending in register 0. The mask register resets to all ones.
- R4: Register 2 holds one force bit per source. A set force bit requests without any hardware input. It stays set until software writes it to 0, and an acknowledge does not change it.
- R5: The request level is the highest priority level among sources that are pending or forced, unmasked, and at a level above 0. It is 0 when no source qualifies.
- R6: The take flag is high when the request level is greater than the core mask input, or when the level is 7. Level 7 cannot be masked.
- R7: One cycle after an acknowledge pulse, the acknowledge-valid output is high for one cycle and the vector output carries 64 plus the index of the winning source. When several sources share the top level, the lowest index wins.
- R8: An acknowledge that arrives while the request level is 0 returns vector 24.
- R9: An acknowledge clears the winner's pending bit if that source is in edge mode. A level-mode source stays pending while its line is high.
- R10: Writing 1 to bit n of register 0 clears the edge-captured pending bit of source n. If a rising edge arrives in the same cycle, the edge wins and the bit stays set.
- R11: Register 3 selects the capture mode per source, where 1 means edge and 0 means level. It resets to all ones. After reset, the pending bits, force bits and levels are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NSRC | Request line of each peripheral source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| core_mask | input | 3 | Current interrupt mask of the core |
| irq_level | output | 3 | Highest requesting level |
| irq_take | output | 1 | Level passes the core mask |
| iack | input | 1 | Acknowledge cycle pulse from the core |
| iack_vld | output | 1 | Vector output valid |
| iack_vec | output | 8 | Vector number returned for the acknowledge |

## Verification
The case that is hardest to reach from the ports is a rising edge on a source in the same cycle that software writes 1 to clear that source's pending bit. The stimulus places the register write and the line transition on one falling edge, so both land on the same rising edge, and then it reads the status back. Another case needs several steps: a source that is pending but masked must stay pending through an acknowledge that returns the spurious vector. The stimulus reaches it by masking the source first and then pulsing its line.

// File: rtl/irq_pkg.sv
// Package: register word addresses and fixed widths that the controller
// and its bench share. Assumes a 4-bit word address and a 32-bit data path.
package irq_pkg;
    localparam int unsigned REG_AW    = 4;
    localparam int unsigned REG_DW    = 32;
    localparam int unsigned LVL_W     = 3;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned SLOT_W    = 4;   // bits per priority field
    localparam int unsigned PER_WORD  = REG_DW / SLOT_W;

    typedef enum logic [REG_AW-1:0] {
        RA_PEND  = 4'd0,
        RA_MASK  = 4'd1,
        RA_FORCE = 4'd2,
        RA_EDGE  = 4'd3,
        RA_PRIO  = 4'd4
    } reg_addr_e;
endpackage

// File: rtl/irq_regs.sv
// Register file and pending capture for the interrupt controller.
// Holds the mask, force, edge-mode and priority registers, and the
// edge-captured pending bits. Assumes NSRC <= 32 and that ack_clr is
// one-hot or zero.
module irq_regs
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_irq,
    input  logic                  we,
    input  logic [REG_AW-1:0]     addr,
    input  logic [REG_DW-1:0]     wdata,
    output logic [REG_DW-1:0]     rdata,
    input  logic [NSRC-1:0]       ack_clr,
    output logic [NSRC-1:0]       pend_eff,
    output logic [NSRC-1:0]       mask_q,
    output logic [NSRC-1:0]       force_q,
    output logic [NSRC*LVL_W-1:0] lvl_flat
);
    logic [NSRC-1:0] src_d;
    logic [NSRC-1:0] edge_q;
    logic [NSRC-1:0] pend_edge;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] w1c;

    assign rise = src_irq & ~src_d;
    assign w1c  = (we && addr == RA_PEND) ? wdata[NSRC-1:0] : '0;

    // Delay the request lines by one cycle for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= src_irq;
    end

    // Mask, force and mode registers, written whole from the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            force_q <= '0;
            edge_q  <= '1;
        end else if (we) begin
            if (addr == RA_MASK)  mask_q  <= wdata[NSRC-1:0];
            if (addr == RA_FORCE) force_q <= wdata[NSRC-1:0];
            if (addr == RA_EDGE)  edge_q  <= wdata[NSRC-1:0];
        end
    end

    // Edge-captured pending bits: a rising edge sets, clears from software and ack.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_edge <= '0;
        else        pend_edge <= ((pend_edge & ~(w1c | ack_clr)) | rise) & edge_q;
    end

    assign pend_eff = (pend_edge & edge_q) | (src_irq & ~edge_q);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_lvl
            localparam logic [REG_AW-1:0] WADDR = REG_AW'(RA_PRIO + g / PER_WORD);
            localparam int unsigned       LSB   = SLOT_W * (g % PER_WORD);
            logic [LVL_W-1:0] lvl_q;
            // Per-source priority level held in its packed field.
            always_ff @(posedge clk) begin
                if (!rst_n)                    lvl_q <= '0;
                else if (we && addr == WADDR)  lvl_q <= wdata[LSB +: LVL_W];
            end
            assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
        end
    endgenerate

    // Combinational read mux over status, control and priority words.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_PEND:  rdata[NSRC-1:0] = pend_eff;
            RA_MASK:  rdata[NSRC-1:0] = mask_q;
            RA_FORCE: rdata[NSRC-1:0] = force_q;
            RA_EDGE:  rdata[NSRC-1:0] = edge_q;
            default: begin
                for (int n = 0; n < NSRC; n++) begin
                    if (addr == REG_AW'(RA_PRIO + n / PER_WORD))
                        rdata[SLOT_W*(n % PER_WORD) +: LVL_W] = lvl_flat[n*LVL_W +: LVL_W];
                end
            end
        endcase
    end

    // R9
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_clr) |=> ((pend_edge & $past(ack_clr & ~rise)) == '0));

    // R4
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == RA_FORCE) |=> $stable(force_q));

    // R10
    rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & edge_q)) |=> ((pend_edge & $past(rise & edge_q)) == $past(rise & edge_q)));
endmodule

// File: rtl/irq_arbiter.sv
// Priority selector: finds the highest level among the requesting sources.
// On a tie, the lowest index wins. A level of 0 never takes part.
// Purely combinational.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned NSRC  = 8,
    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic                  win_vld,
    output logic [IDX_W-1:0]      win_idx,
    output logic [LVL_W-1:0]      win_lvl
);
    // Walk from the top index down; >= lets a lower index take a tie.
    always_comb begin
        win_lvl = '0;
        win_idx = '0;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (req[n] && lvl_flat[n*LVL_W +: LVL_W] != '0 &&
                lvl_flat[n*LVL_W +: LVL_W] >= win_lvl) begin
                win_lvl = lvl_flat[n*LVL_W +: LVL_W];
                win_idx = IDX_W'(n);
            end
        end
        win_vld = (win_lvl != '0);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top level of the prioritized interrupt controller. It combines the
// pending and forced requests, applies the masks, presents the winning
// level to the core, and answers acknowledge cycles with a vector number.
// Assumes iack is a single-cycle pulse and NSRC <= 32.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NSRC     = 8,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned SPUR_VEC = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_irq,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic [LVL_W-1:0]     core_mask,
    output logic [LVL_W-1:0]     irq_level,
    output logic                 irq_take,
    input  logic                 iack,
    output logic                 iack_vld,
    output logic [VEC_W-1:0]     iack_vec
);
    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]       pend_eff, mask_q, force_q, req, ack_clr;
    logic [NSRC*LVL_W-1:0] lvl_flat;
    logic                  win_vld;
    logic [IDX_W-1:0]      win_idx;
    logic [LVL_W-1:0]      win_lvl;

    irq_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .ack_clr(ack_clr), .pend_eff(pend_eff), .mask_q(mask_q),
        .force_q(force_q), .lvl_flat(lvl_flat)
    );

    assign req = (pend_eff | force_q) & ~mask_q;

    irq_arbiter #(.NSRC(NSRC)) u_arb (
        .req(req), .lvl_flat(lvl_flat),
        .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign irq_level = win_lvl;
    assign irq_take  = (win_lvl > core_mask) || (win_lvl == '1);
    assign ack_clr   = (iack && win_vld) ? (NSRC'(1) << win_idx) : '0;

    // Register the vector answer one cycle after the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iack_vld <= 1'b0;
            iack_vec <= '0;
        end else begin
            iack_vld <= iack;
            if (iack)
                iack_vec <= win_vld ? VEC_W'(VEC_BASE) + VEC_W'(win_idx)
                                    : VEC_W'(SPUR_VEC);
        end
    end

    // R6
    nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd7) |-> irq_take);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (irq_level == '0));

    // R7
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack |=> iack_vld);

    // R8
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && irq_level == '0) |=> (iack_vec == VEC_W'(SPUR_VEC)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    import irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_irq = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  core_mask = '0;
    logic [2:0]  irq_level;
    logic        irq_take;
    logic        iack = 1'b0;
    logic        iack_vld;
    logic [7:0]  iack_vec;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_mask(core_mask), .irq_level(irq_level),
        .irq_take(irq_take), .iack(iack), .iack_vld(iack_vld), .iack_vec(iack_vec)
    );

    // Vector fields: force[62:55] mask[54:47] prio[46:15] cmask[14:12]
    // exp_level[11:9] exp_take[8] exp_vec[7:0]
    localparam logic [62:0] TBL [8] = '{
        {8'h01, 8'h00, 32'h3333_3333, 3'd0, 3'd3, 1'b1, 8'd64},
        {8'h88, 8'h00, 32'h5111_5111, 3'd0, 3'd5, 1'b1, 8'd67},
        {8'hFF, 8'hFF, 32'h7777_7777, 3'd0, 3'd0, 1'b0, 8'd24},
        {8'h0C, 8'h04, 32'h0000_2600, 3'd2, 3'd2, 1'b0, 8'd67},
        {8'h80, 8'h00, 32'h7000_0000, 3'd7, 3'd7, 1'b1, 8'd71},
        {8'h40, 8'h00, 32'h0600_0000, 3'd7, 3'd6, 1'b0, 8'd70},
        {8'h03, 8'h00, 32'h0000_0040, 3'd3, 3'd4, 1'b1, 8'd65},
        {8'h01, 8'h00, 32'h0000_0000, 3'd0, 3'd0, 1'b0, 8'd24}
    };

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack(output logic [7:0] v, output logic vld);
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        vld = iack_vld;
        v = iack_vec;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        src_irq[n] = 1'b1;
        @(negedge clk);
        src_irq[n] = 1'b0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  v;
        logic        vl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R3: reset state
        rd(RA_MASK, r);  chk("R3 mask reset", r, 32'hFF);
        rd(RA_EDGE, r);  chk("R11 edge reset", r, 32'hFF);
        rd(RA_PEND, r);  chk("R11 pend reset", r, 32'h0);
        rd(RA_FORCE, r); chk("R11 force reset", r, 32'h0);
        chk("R5 level reset", 32'(irq_level), 32'd0);
        chk("R7 vld reset", 32'(iack_vld), 32'd0);

        // Table walk: force-driven requests (R1 R4 R5 R6 R7 R8)
        for (int i = 0; i < 8; i++) begin
            wr(RA_MASK, {24'h0, TBL[i][54:47]});
            wr(RA_PRIO, TBL[i][46:15]);
            wr(RA_FORCE, {24'h0, TBL[i][62:55]});
            core_mask = TBL[i][14:12];
            #1;
            chk("R5 table level", 32'(irq_level), 32'(TBL[i][11:9]));
            chk("R6 table take", 32'(irq_take), 32'(TBL[i][8]));
            ack(v, vl);
            chk("R7 table vld", 32'(vl), 32'd1);
            chk("R7 R8 table vec", 32'(v), 32'(TBL[i][7:0]));
        end

        wr(RA_FORCE, 32'h0);
        wr(RA_MASK, 32'h0);
        wr(RA_PRIO, 32'h0000_0321);
        core_mask = 3'd0;

        // R2 R9: edge capture and clear on acknowledge
        pulse(1);
        rd(RA_PEND, r); chk("R2 edge pend", r, 32'h02);
        chk("R1 level of src1", 32'(irq_level), 32'd2);
        ack(v, vl);
        chk("R7 edge vec", 32'(v), 32'd65);
        rd(RA_PEND, r); chk("R9 edge cleared by ack", r, 32'h0);

        // R10: write-one-to-clear
        pulse(2);
        rd(RA_PEND, r); chk("R2 src2 pend", r, 32'h04);
        wr(RA_PEND, 32'h04);
        rd(RA_PEND, r); chk("R10 w1c", r, 32'h0);

        // R10: rising edge in the same cycle as the clear write
        @(negedge clk);
        src_irq[2] = 1'b1;
        reg_we = 1'b1; reg_addr = RA_PEND; reg_wdata = 32'h04;
        @(negedge clk);
        reg_we = 1'b0; src_irq[2] = 1'b0;
        rd(RA_PEND, r); chk("R10 rise beats w1c", r, 32'h04);
        wr(RA_PEND, 32'h04);

        // R9 R11: level-mode source not cleared by acknowledge
        wr(RA_EDGE, 32'hFE);
        @(negedge clk); src_irq[0] = 1'b1;
        rd(RA_PEND, r); chk("R2 level pend", r, 32'h01);
        ack(v, vl);
        chk("R7 level vec", 32'(v), 32'd64);
        rd(RA_PEND, r); chk("R9 level stays", r, 32'h01);
        @(negedge clk); src_irq[0] = 1'b0;
        rd(RA_PEND, r); chk("R2 level drops", r, 32'h0);
        wr(RA_EDGE, 32'hFF);

        // R4: force survives an acknowledge
        wr(RA_FORCE, 32'h02);
        ack(v, vl);
        chk("R4 forced vec", 32'(v), 32'd65);
        rd(RA_FORCE, r); chk("R4 force held", r, 32'h02);
        wr(RA_FORCE, 32'h0);

        // R3 R8: masked pending source stays pending, ack is spurious
        wr(RA_MASK, 32'h02);
        pulse(1);
        rd(RA_PEND, r); chk("R3 masked still pending", r, 32'h02);
        chk("R3 masked level", 32'(irq_level), 32'd0);
        ack(v, vl);
        chk("R8 spurious", 32'(v), 32'd24);
        rd(RA_PEND, r); chk("R9 non-winner kept", r, 32'h02);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule